// File: doc/BRIEF.md
# Cascaded Interval Timer

This block is a slow interval timer made of two 8-bit counters in cascade. Counter A advances on a slow auxiliary tick. Counter B advances on one of three sources: the same auxiliary tick, a faster subsystem tick, or the wrap-around carry of counter A, which divides the auxiliary tick by 256. One 8-bit control register sets the source for counter B, a hold bit, a refresh-rate code and an interval code.

The block has two outputs. A sticky interrupt flag is set each time the selected bit of counter B goes from 0 to 1. A single-cycle refresh strobe fires each time the selected upper bit of counter A goes from 0 to 1. Everything runs on one system clock. Each source clock arrives as a one-cycle enable pulse, so the design contains no derived clock.

Software reads and writes the control register, both counters and the flag through a small register port. The flag is held in a two-state machine. In state `FLG_CLEAR` the flag output is 0. The transition `set` (an interval event) moves it to `FLG_PENDING`, where the flag output is 1. The transition `clear` (a software write of 1 to the clear bit, with no event in the same cycle) returns it to `FLG_CLEAR`.

Top module: `cascade_timer`

## Requirements
- R1: After reset the control register, both counters and the flag read as zero, so counter B runs from the auxiliary tick with interval code 0.
- R2: Counter A rises by one for every cycle in which `aux_tick` is high and the counter is not frozen. It wraps from 255 to 0, and that wrap is the divide-by-256 carry.
- R3: The source of counter B is chosen by control bits {7,5}: 00 selects `aux_tick`, 10 selects `sub_tick`, and 01 or 11 select the carry of counter A.
- R4: With control bit 6 (hold) at 1, counter B never advances. Counter A is frozen only when bit 5 is also 1. With bit 6 at 0, both counters run.
- R5: For interval code n (control bits 2:0), an interval event occurs when bit n of counter B goes from 0 to 1 through an increment. Events therefore repeat every 2^(n+1) advances of counter B.
- R6: For refresh code f (control bits 4:3), `refresh_strobe` is high for exactly the cycles in which bit 4+f of counter A goes from 0 to 1 through an increment. It repeats every 32, 64, 128 or 256 auxiliary ticks.
- R7: An interval event sets `irq_flag`. The flag stays at 1 until a write to address 3 with data bit 0 set. A write with bit 0 at 0 leaves it set. An event in the same cycle as a clear keeps it set.
- R8: The addresses map as follows: 0 is the control register, 1 is counter A, 2 is counter B, and 3 reads {7'b0, flag}. Reads are combinational. A write to address 1 or 2 loads that counter in the next cycle, takes precedence over counting, and produces no interval event or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_tick | input | 1 | One-cycle pulse per auxiliary clock period |
| sub_tick | input | 1 | One-cycle pulse per subsystem clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_flag | output | 1 | Sticky interval flag |
| refresh_strobe | output | 1 | Single-cycle refresh pulse |

## Verification
Every interval code is exercised with an auxiliary tick on every cycle, and the spacing of flag settings is measured. That spacing distinguishes each tap bit from its neighbours. The refresh codes are measured the same way. Each source combination is run first with only subsystem ticks and then with only auxiliary ticks, starting with counter A near its wrap, so that a wrongly routed source shows up as an exact count mismatch. All four hold and divide combinations are run the same way to separate a frozen counter A from a running one. A long phase with random ticks, random writes and random read addresses is compared on every clock against a behavioural model, which covers simultaneous set and clear and loads that land on a tap edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int IVT_W   = 8;
    localparam int FRQ_W   = 2;
    localparam int IVL_W   = 3;
    localparam int FRQ_TAP = 4;

    typedef struct packed {
        logic             src_sel;
        logic             hold;
        logic             div;
        logic [FRQ_W-1:0] frq;
        logic [IVL_W-1:0] ivl;
    } ivt_ctrl_t;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CNTA = 2'd1,
        A_CNTB = 2'd2,
        A_FLAG = 2'd3
    } ivt_addr_e;

    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_PENDING = 1'b1
    } ivt_flag_e;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int W        = 8,
    parameter int TSW      = 3,
    parameter int TAP_BASE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           run,
    input  logic           load,
    input  logic [W-1:0]   load_val,
    input  logic [TSW-1:0] tap_sel,
    output logic [W-1:0]   count,
    output logic           carry,
    output logic           tap_rise
);
    localparam int IW = $clog2(W);

    logic          adv;
    logic [W-1:0]  nxt;
    logic [IW-1:0] tap_idx;

    assign adv      = tick & run & ~load;
    assign nxt      = count + W'(1);
    assign tap_idx  = IW'(TAP_BASE) + IW'(tap_sel);
    assign carry    = adv & (&count);
    assign tap_rise = adv & ~count[tap_idx] & nxt[tap_idx];

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (load)   count <= load_val;
        else if (adv)    count <= nxt;
    end

    // R2: each advance raises the value by one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !load) |=> count == $past(count) + W'(1));
    // R2: a carry is followed by a zero count
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> count == '0);
    // R8: a load takes the written value
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R4: a stopped counter keeps its value
    p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));
endmodule

// File: rtl/ivt_flag.sv
module ivt_flag
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_req,
    output logic flag
);
    ivt_flag_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FLG_CLEAR;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FLG_CLEAR:   if (set_ev)              state_nxt = FLG_PENDING;
            FLG_PENDING: if (clr_req && !set_ev)  state_nxt = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state == FLG_PENDING);
    end

    // R7: an event always leaves the flag set
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);
    // R7: without a clear the flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    // R7: a clear with no event drops it
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_ev) |=> !flag);
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ivt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aux_tick,
    input  logic             sub_tick,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [IVT_W-1:0] bus_wdata,
    output logic [IVT_W-1:0] bus_rdata,
    output logic             irq_flag,
    output logic             refresh_strobe
);
    ivt_ctrl_t        ctrl;
    logic             ld_a, ld_b, wr_ctrl, clr_req;
    logic             run_a, run_b, src_b;
    logic [IVT_W-1:0] cnt_a, cnt_b;
    logic             carry_a, carry_b, ivl_rise;

    assign wr_ctrl = bus_wr && (ivt_addr_e'(bus_addr) == A_CTRL);
    assign ld_a    = bus_wr && (ivt_addr_e'(bus_addr) == A_CNTA);
    assign ld_b    = bus_wr && (ivt_addr_e'(bus_addr) == A_CNTB);
    assign clr_req = bus_wr && (ivt_addr_e'(bus_addr) == A_FLAG) && bus_wdata[0];

    assign run_a = ~(ctrl.hold & ctrl.div);
    assign run_b = ~ctrl.hold;

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ivt_ctrl_t'(bus_wdata);
    end

    always_comb begin
        unique case ({ctrl.src_sel, ctrl.div})
            2'b00:   src_b = aux_tick;
            2'b10:   src_b = sub_tick;
            default: src_b = carry_a;
        endcase
    end

    ivt_counter #(.W(IVT_W), .TSW(FRQ_W), .TAP_BASE(FRQ_TAP)) i_cnt_a (
        .clk(clk), .rst_n(rst_n), .tick(aux_tick), .run(run_a),
        .load(ld_a), .load_val(bus_wdata), .tap_sel(ctrl.frq),
        .count(cnt_a), .carry(carry_a), .tap_rise(refresh_strobe)
    );

    ivt_counter #(.W(IVT_W), .TSW(IVL_W), .TAP_BASE(0)) i_cnt_b (
        .clk(clk), .rst_n(rst_n), .tick(src_b), .run(run_b),
        .load(ld_b), .load_val(bus_wdata), .tap_sel(ctrl.ivl),
        .count(cnt_b), .carry(carry_b), .tap_rise(ivl_rise)
    );

    ivt_flag i_flag (
        .clk(clk), .rst_n(rst_n), .set_ev(ivl_rise), .clr_req(clr_req),
        .flag(irq_flag)
    );

    always_comb begin
        unique case (ivt_addr_e'(bus_addr))
            A_CTRL: bus_rdata = ctrl;
            A_CNTA: bus_rdata = cnt_a;
            A_CNTB: bus_rdata = cnt_b;
            A_FLAG: bus_rdata = {{(IVT_W-1){1'b0}}, irq_flag};
        endcase
    end

    // R4: hold freezes counter B
    p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hold && !ld_b) |=> cnt_b == $past(cnt_b));
    // R4: hold with divide freezes counter A
    p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hold && ctrl.div && !ld_a) |=> cnt_a == $past(cnt_a));
    // R3: the cascade carry advances counter B
    p_cascade_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.div && !ctrl.hold && carry_a && !ld_b) |=> cnt_b == $past(cnt_b) + 8'd1);
    // R3: subsystem tick advances counter B when selected
    p_subsrc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src_sel && !ctrl.div && !ctrl.hold && sub_tick && !ld_b)
        |=> cnt_b == $past(cnt_b) + 8'd1);
    // R5: counter B wraps to zero
    p_bwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_b |=> cnt_b == '0);
    // R6: the strobe only fires on an auxiliary tick
    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_strobe |-> (aux_tick && !ld_a));
endmodule

// File: tb/test_cascade_timer.sv
module test_cascade_timer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aux_tick = 1'b0, sub_tick = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_flag, refresh_strobe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural model
    int       ma = 0, mb = 0, mflag = 0;
    bit [7:0] mctrl = 8'd0;

    always #(CLK_P/2) clk = ~clk;

    cascade_timer i_cascade_timer (
        .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .sub_tick(sub_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_flag(irq_flag), .refresh_strobe(refresh_strobe)
    );

    function automatic int bitof(int v, int i);
        return (v >> i) & 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ma = 0; mb = 0; mflag = 0; mctrl = 8'd0;
        end else begin
            bit la, lb, adv_a, adv_b, carry, src, ev;
            la    = bus_wr && bus_addr == 2'd1;
            lb    = bus_wr && bus_addr == 2'd2;
            adv_a = aux_tick && !(mctrl[6] && mctrl[5]) && !la;
            carry = adv_a && ma == 255;
            src   = mctrl[5] ? carry : (mctrl[7] ? sub_tick : aux_tick);
            adv_b = src && !mctrl[6] && !lb;
            ev    = adv_b && bitof(mb, mctrl[2:0]) == 0 && bitof((mb + 1) & 255, mctrl[2:0]) == 1;
            if (ev) mflag = 1;
            else if (bus_wr && bus_addr == 2'd3 && bus_wdata[0]) mflag = 0;
            if (la) ma = bus_wdata; else if (adv_a) ma = (ma + 1) & 255;
            if (lb) mb = bus_wdata; else if (adv_b) mb = (mb + 1) & 255;
            if (bus_wr && bus_addr == 2'd0) mctrl = bus_wdata;
        end
    end

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            bit adv_a, es;
            int tap, er;
            tap   = 4 + mctrl[4:3];
            adv_a = aux_tick && !(mctrl[6] && mctrl[5]) && !(bus_wr && bus_addr == 2'd1);
            es    = adv_a && bitof(ma, tap) == 0 && bitof((ma + 1) & 255, tap) == 1;
            check(refresh_strobe == es, "R6 model strobe", refresh_strobe, es);
            check(irq_flag == mflag[0], "R7 model flag", irq_flag, mflag);
            case (bus_addr)
                2'd0: begin er = mctrl; check(bus_rdata == er, "R8 model ctrl", bus_rdata, er); end
                2'd1: begin er = ma; check(bus_rdata == er, "R2 model counter A", bus_rdata, er); end
                2'd2: begin er = mb; check(bus_rdata == er, "R3 model counter B", bus_rdata, er); end
                default: begin er = mflag; check(bus_rdata == er, "R5 model flag read", bus_rdata, er); end
            endcase
        end
    end

    task automatic cyc(input bit a, input bit s, input bit w, input logic [1:0] ad, input logic [7:0] wd);
        @(negedge clk);
        aux_tick = a; sub_tick = s; bus_wr = w; bus_addr = ad; bus_wdata = wd;
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] ad, input logic [7:0] wd);
        cyc(1'b0, 1'b0, 1'b1, ad, wd);
    endtask

    task automatic rd_reg(input logic [1:0] ad, output int v);
        cyc(1'b0, 1'b0, 1'b0, ad, 8'd0);
        v = bus_rdata;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int v, k;
        repeat (3) cyc(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: everything reads zero after reset
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            check(v == 0, "R1 reset value", v, 0);
        end
        check(irq_flag == 1'b0, "R1 reset flag", irq_flag, 0);

        // R5: interval period for every code
        for (int n = 0; n < 8; n++) begin
            wr_reg(2'd0, 8'(n));
            wr_reg(2'd2, 8'd0);
            wr_reg(2'd3, 8'd1);
            k = 0;
            do begin cyc(1'b1, 1'b0, 1'b0, 2'd3, 8'd0); k++; end while (!irq_flag && k < 600);
            cyc(1'b1, 1'b0, 1'b1, 2'd3, 8'd1);
            k = 1;
            do begin cyc(1'b1, 1'b0, 1'b0, 2'd3, 8'd0); k++; end while (!irq_flag && k < 600);
            check(k == (2 << n), "R5 interval period", k, 2 << n);
        end

        // R6: refresh period for every code
        for (int f = 0; f < 4; f++) begin
            wr_reg(2'd0, 8'(f << 3));
            k = 0;
            do begin cyc(1'b1, 1'b0, 1'b0, 2'd1, 8'd0); k++; end while (!refresh_strobe && k < 600);
            k = 0;
            do begin cyc(1'b1, 1'b0, 1'b0, 2'd1, 8'd0); k++; end while (!refresh_strobe && k < 600);
            check(k == (32 << f), "R6 refresh period", k, 32 << f);
        end

        // R4: hold and divide combinations
        for (int h = 0; h < 2; h++) begin
            for (int d = 0; d < 2; d++) begin
                int ea, eb;
                wr_reg(2'd1, 8'd250);
                wr_reg(2'd2, 8'd7);
                wr_reg(2'd0, 8'((h << 6) | (d << 5)));
                repeat (20) cyc(1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
                ea = (h == 1 && d == 1) ? 250 : 14;
                eb = (h == 1) ? 7 : (d == 1 ? 8 : 27);
                rd_reg(2'd1, v); check(v == ea, "R4 hold counter A", v, ea);
                rd_reg(2'd2, v); check(v == eb, "R4 hold counter B", v, eb);
            end
        end

        // R3: source selection
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 2; d++) begin
                int eb;
                wr_reg(2'd1, 8'd250);
                wr_reg(2'd2, 8'd0);
                wr_reg(2'd0, 8'((s << 7) | (d << 5)));
                repeat (10) cyc(1'b0, 1'b1, 1'b0, 2'd2, 8'd0);
                repeat (10) cyc(1'b1, 1'b0, 1'b0, 2'd2, 8'd0);
                eb = ((s == 1 && d == 0) ? 10 : 0) + (d == 1 ? 1 : (s == 0 ? 10 : 0));
                rd_reg(2'd2, v); check(v == eb, "R3 source count B", v, eb);
                rd_reg(2'd1, v); check(v == 4, "R2 counter A wrap", v, 4);
            end
        end

        // R7: writing 0 to the clear bit keeps the flag
        wr_reg(2'd0, 8'd0);
        wr_reg(2'd2, 8'd0);
        cyc(1'b1, 1'b0, 1'b0, 2'd3, 8'd0);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'd0);
        check(irq_flag == 1'b1, "R7 flag set", irq_flag, 1);
        wr_reg(2'd3, 8'hFE);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'd0);
        check(irq_flag == 1'b1, "R7 write 0 ignored", irq_flag, 1);
        wr_reg(2'd3, 8'd1);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'd0);
        check(irq_flag == 1'b0, "R7 clear", irq_flag, 0);

        // R8: a load across a tap edge makes no event
        wr_reg(2'd2, 8'd1);
        cyc(1'b0, 1'b0, 1'b0, 2'd2, 8'd0);
        check(irq_flag == 1'b0, "R8 load no event", irq_flag, 0);
        check(bus_rdata == 8'd1, "R8 load value", bus_rdata, 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            bit w;
            w = ($urandom_range(15) == 0);
            cyc(1'($urandom_range(1)), 1'($urandom_range(1)), w,
                2'($urandom_range(3)), 8'($urandom_range(255)));
        end

        cyc(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        done = 1'b1;
        finish_run();
    end
endmodule